// File: doc/BRIEF.md
# Bundled Instruction Completion Tracker

The tracker sits between dispatch and the per-unit issue queues of an out-of-order core. Dispatch hands over a bundle of up to five instruction tags with a slot mask. The tracker opens an entry in a circular ring of 20 group entries and names that entry by its group ID. In the same cycle it forwards the slot mask, the group ID and the tags to the issue side, so each instruction travels as the pair (group ID, slot index). Execution units later report finished instructions out of order on two finish ports. Each report carries a group ID and a slot index. The tracker records the report in a per-entry finished mask.

Commit happens per bundle, not per instruction. A group retires only when it is the oldest live group and its finished mask equals its slot mask. At most one group retires per cycle. A flush names a live group and clears that group and every younger one. The next dispatch then reuses the flushed group ID. Malformed finish reports set a sticky error output.

The ring occupancy is a three-state machine: OCC_EMPTY, OCC_PARTIAL and OCC_FULL. The transitions are:
- EMPTY to PARTIAL on an allocation.
- PARTIAL to FULL when the count reaches 20.
- FULL to PARTIAL on a retire or on a partial flush.
- PARTIAL to EMPTY on the last retire, or on a flush of the oldest group.
- FULL to EMPTY on a flush of the oldest group.

The next state always follows from the next occupancy count.

Top module: `grp_cmpl_tracker`

## Requirements
- R1: After reset the ring is empty (state OCC_EMPTY), `disp_ready` is 1, `ret_valid` is 0 and `err_flag` is 0. No group ever retires while the ring is empty.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both 1 and `disp_mask` is nonzero. The group ID it gets is shown on `disp_gid`. IDs run 0,1,…,19 and then wrap to 0. In the accepting cycle `iss_mask` equals `disp_mask`, `iss_gid` equals the new ID and `iss_tags` equals `disp_tags`. In any other cycle `iss_mask` is 0.
- R3: A dispatch with `disp_mask` equal to 0 allocates nothing, so the next accepted dispatch receives the same group ID. A live entry never holds an all-zero slot mask.
- R4: `disp_ready` is 0 while 20 groups are live or while `flush_valid` is 1. A dispatch offered then allocates nothing.
- R5: `ret_valid` is 1 exactly when the oldest live group has every slot of its mask finished. `ret_mask` gives that slot mask (bit i is slot i). `ret_valid` rises in the cycle after the edge that records the last finish, and the group leaves at the next edge.
- R6: Groups retire strictly in dispatch order on `ret_gid`. A younger group whose slots are all finished waits behind an unfinished older one.
- R7: Two finish reports in one cycle that name the same group set both finished bits.
- R8: A flush whose `flush_gid` names a live group clears that group and all younger groups. The next accepted dispatch receives `flush_gid`. Older groups keep their state and can still retire in the flush cycle. A flush naming a non-live ID changes nothing.
- R9: A finish report naming an ID of 20 or more, a non-live group, a slot index of 5 or more, or a slot outside the group's mask changes no entry. It sets `err_flag`, which stays 1 until reset.
- R10: A finish report arriving in the same cycle as a flush that clears its group is dropped without setting `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch bundle offered |
| disp_mask | input | SLOTS (5) | Occupied slots of the bundle |
| disp_tags | input | SLOTS*TAG_W (40) | Slot tags, slot i at bits i*TAG_W upward |
| disp_ready | output | 1 | Bundle can be accepted this cycle |
| disp_gid | output | GID_W (5) | Group ID the offered bundle would receive |
| iss_mask | output | SLOTS (5) | Slots forwarded to the issue queues this cycle |
| iss_gid | output | GID_W (5) | Group ID of the forwarded slots |
| iss_tags | output | SLOTS*TAG_W (40) | Forwarded tags |
| fin_valid | input | PORTS (2) | Finish report valid per port |
| fin_gid | input | PORTS*GID_W (10) | Group ID per port, port p at bits p*GID_W upward |
| fin_slot | input | PORTS*SLOT_W (6) | Slot index per port, port p at bits p*SLOT_W upward |
| flush_valid | input | 1 | Flush request |
| flush_gid | input | GID_W (5) | Oldest group to discard |
| ret_valid | output | 1 | Oldest group retires at this edge |
| ret_gid | output | GID_W (5) | ID of the retiring group |
| ret_mask | output | SLOTS (5) | Slot mask of the retiring group |
| err_flag | output | 1 | Sticky bad-finish indicator |

## Verification
The bench builds the tracker with its defaults: five slots, 20 groups, two finish ports and 8-bit tags. Twenty entries is a non-power-of-two depth. With it a few hundred random cycles are enough to wrap the pointers past 19 many times, to reach the full ring, and to drive flush ages that straddle the wrap point. The 5-bit ID and 3-bit slot fields leave spare codes (20 to 31 and 5 to 7). The bench uses these spare codes to exercise the out-of-range error paths.

// File: rtl/grp_trk_pkg.sv
package grp_trk_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    // distance of entry g from the oldest entry h in a ring of 'groups'
    function automatic int ring_age(input int g, input int h, input int groups);
        int d;
        d = g - h;
        if (d < 0) d = d + groups;
        return d;
    endfunction

    function automatic int ring_next(input int p, input int groups);
        return (p == groups - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/grp_ring_ctrl.sv
module grp_ring_ctrl
    import grp_trk_pkg::*;
#(
    parameter int GROUPS = 20,
    parameter int GID_W  = 5,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_req,
    input  logic             head_done,
    input  logic             flush_req,
    input  logic [GID_W-1:0] flush_gid,
    output logic             alloc_fire,
    output logic             retire_fire,
    output logic             flush_fire,
    output logic [CNT_W-1:0] flush_age,
    output logic [GID_W-1:0] head,
    output logic [GID_W-1:0] tail,
    output logic             ready
);

    occ_state_e       state_q, state_n;
    logic [CNT_W-1:0] count_q, count_n;
    logic [GID_W-1:0] head_q, head_n, tail_q, tail_n;
    logic             ready_st, has_old;
    int               fl_age;

    // decisions for this cycle
    always_comb begin
        fl_age      = ring_age(int'(flush_gid), int'(head_q), GROUPS);
        flush_fire  = flush_req && (int'(flush_gid) < GROUPS) && (fl_age < int'(count_q));
        flush_age   = CNT_W'(fl_age);
        retire_fire = has_old && head_done && !(flush_fire && (flush_gid == head_q));
        alloc_fire  = disp_req && ready_st && !flush_req;
    end

    // pointer, count and next-state logic
    always_comb begin
        head_n = retire_fire ? GID_W'(ring_next(int'(head_q), GROUPS)) : head_q;
        if (flush_fire) begin
            tail_n  = flush_gid;
            count_n = flush_age - CNT_W'(retire_fire);
        end else begin
            tail_n  = alloc_fire ? GID_W'(ring_next(int'(tail_q), GROUPS)) : tail_q;
            count_n = count_q + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
        end
        if (count_n == '0) begin
            state_n = OCC_EMPTY;
        end else if (count_n == CNT_W'(GROUPS)) begin
            state_n = OCC_FULL;
        end else begin
            state_n = OCC_PARTIAL;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_n;
            count_q <= count_n;
            head_q  <= head_n;
            tail_q  <= tail_n;
        end
    end

    // state outputs
    always_comb begin
        ready_st = 1'b0;
        has_old  = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin
                ready_st = 1'b1;
                has_old  = 1'b0;
            end
            OCC_PARTIAL: begin
                ready_st = 1'b1;
                has_old  = 1'b1;
            end
            OCC_FULL: begin
                ready_st = 1'b0;
                has_old  = 1'b1;
            end
            default: begin
                ready_st = 1'b0;
                has_old  = 1'b0;
            end
        endcase
    end

    assign ready = ready_st && !flush_req;
    assign head  = head_q;
    assign tail  = tail_q;

    p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_W'(GROUPS)) |-> !alloc_fire);

    p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) |-> !retire_fire);

    p_head_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retire_fire |=> (head_q != $past(head_q)));

    p_flush_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fire |=> (tail_q == $past(flush_gid)));

endmodule

// File: rtl/grp_fin_check.sv
module grp_fin_check #(
    parameter int GROUPS = 20,
    parameter int SLOTS  = 5,
    parameter int PORTS  = 2,
    parameter int GID_W  = 5,
    parameter int SLOT_W = 3
) (
    input  logic [PORTS-1:0]                 fin_valid,
    input  logic [PORTS-1:0][GID_W-1:0]      fin_gid,
    input  logic [PORTS-1:0][SLOT_W-1:0]     fin_slot,
    input  logic [GROUPS-1:0]                live,
    input  logic [GROUPS-1:0][SLOTS-1:0]     vmask,
    input  logic [GROUPS-1:0]                kill,
    output logic [GROUPS-1:0][SLOTS-1:0]     set_bits,
    output logic                             bad
);

    always_comb begin
        set_bits = '0;
        bad      = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            int g;
            int s;
            g = int'(fin_gid[p]);
            s = int'(fin_slot[p]);
            if (fin_valid[p]) begin
                if ((g < GROUPS) && kill[g]) begin
                    // target is being discarded this cycle: dropped quietly
                end else if ((g >= GROUPS) || (s >= SLOTS)) begin
                    bad = 1'b1;
                end else if (!live[g] || !vmask[g][s]) begin
                    bad = 1'b1;
                end else begin
                    set_bits[g][s] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/grp_slot_table.sv
module grp_slot_table
    import grp_trk_pkg::*;
#(
    parameter int GROUPS = 20,
    parameter int SLOTS  = 5,
    parameter int GID_W  = 5,
    parameter int CNT_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [GID_W-1:0]             head,
    input  logic [GID_W-1:0]             tail,
    input  logic                         alloc_fire,
    input  logic [SLOTS-1:0]             alloc_mask,
    input  logic                         retire_fire,
    input  logic                         flush_fire,
    input  logic [CNT_W-1:0]             flush_age,
    input  logic [GROUPS-1:0][SLOTS-1:0] set_bits,
    output logic [GROUPS-1:0]            live,
    output logic [GROUPS-1:0][SLOTS-1:0] vmask,
    output logic [GROUPS-1:0]            kill,
    output logic                         head_done,
    output logic [SLOTS-1:0]             head_mask
);

    logic [GROUPS-1:0][SLOTS-1:0] fmask;

    for (genvar e = 0; e < GROUPS; e++) begin : g_ent
        logic             lv_r;
        logic [SLOTS-1:0] vm_r;
        logic [SLOTS-1:0] fm_r;
        logic             is_tail, is_head;

        assign is_tail = (tail == GID_W'(e));
        assign is_head = (head == GID_W'(e));
        assign kill[e] = flush_fire &&
                         (ring_age(e, int'(head), GROUPS) >= int'(flush_age));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lv_r <= 1'b0;
                vm_r <= '0;
                fm_r <= '0;
            end else if (alloc_fire && is_tail) begin
                lv_r <= 1'b1;
                vm_r <= alloc_mask;
                fm_r <= '0;
            end else if (kill[e] || (retire_fire && is_head)) begin
                lv_r <= 1'b0;
                vm_r <= '0;
                fm_r <= '0;
            end else begin
                fm_r <= fm_r | set_bits[e];
            end
        end

        assign live[e]  = lv_r;
        assign vmask[e] = vm_r;
        assign fmask[e] = fm_r;

        p_live_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
            lv_r |-> (vm_r != '0));
    end

    assign head_mask = vmask[head];
    assign head_done = live[head] && (fmask[head] == vmask[head]);

endmodule

// File: rtl/grp_cmpl_tracker.sv
module grp_cmpl_tracker #(
    parameter int SLOTS  = 5,
    parameter int GROUPS = 20,
    parameter int PORTS  = 2,
    parameter int TAG_W  = 8,
    localparam int GID_W  = $clog2(GROUPS),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(GROUPS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    disp_valid,
    input  logic [SLOTS-1:0]        disp_mask,
    input  logic [SLOTS*TAG_W-1:0]  disp_tags,
    output logic                    disp_ready,
    output logic [GID_W-1:0]        disp_gid,
    output logic [SLOTS-1:0]        iss_mask,
    output logic [GID_W-1:0]        iss_gid,
    output logic [SLOTS*TAG_W-1:0]  iss_tags,
    input  logic [PORTS-1:0]        fin_valid,
    input  logic [PORTS*GID_W-1:0]  fin_gid,
    input  logic [PORTS*SLOT_W-1:0] fin_slot,
    input  logic                    flush_valid,
    input  logic [GID_W-1:0]        flush_gid,
    output logic                    ret_valid,
    output logic [GID_W-1:0]        ret_gid,
    output logic [SLOTS-1:0]        ret_mask,
    output logic                    err_flag
);

    logic                         alloc_fire, retire_fire, flush_fire;
    logic [CNT_W-1:0]             flush_age;
    logic [GID_W-1:0]             head, tail;
    logic                         head_done, bad, err_q;
    logic [SLOTS-1:0]             head_mask;
    logic [GROUPS-1:0]            live, kill;
    logic [GROUPS-1:0][SLOTS-1:0] vmask, set_bits;
    logic [PORTS-1:0][GID_W-1:0]  fin_gid_a;
    logic [PORTS-1:0][SLOT_W-1:0] fin_slot_a;

    assign fin_gid_a  = fin_gid;
    assign fin_slot_a = fin_slot;

    grp_ring_ctrl #(
        .GROUPS(GROUPS), .GID_W(GID_W), .CNT_W(CNT_W)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_req   (disp_valid && (|disp_mask)),
        .head_done  (head_done),
        .flush_req  (flush_valid),
        .flush_gid  (flush_gid),
        .alloc_fire (alloc_fire),
        .retire_fire(retire_fire),
        .flush_fire (flush_fire),
        .flush_age  (flush_age),
        .head       (head),
        .tail       (tail),
        .ready      (disp_ready)
    );

    grp_slot_table #(
        .GROUPS(GROUPS), .SLOTS(SLOTS), .GID_W(GID_W), .CNT_W(CNT_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .tail       (tail),
        .alloc_fire (alloc_fire),
        .alloc_mask (disp_mask),
        .retire_fire(retire_fire),
        .flush_fire (flush_fire),
        .flush_age  (flush_age),
        .set_bits   (set_bits),
        .live       (live),
        .vmask      (vmask),
        .kill       (kill),
        .head_done  (head_done),
        .head_mask  (head_mask)
    );

    grp_fin_check #(
        .GROUPS(GROUPS), .SLOTS(SLOTS), .PORTS(PORTS),
        .GID_W(GID_W), .SLOT_W(SLOT_W)
    ) u_fin (
        .fin_valid(fin_valid),
        .fin_gid  (fin_gid_a),
        .fin_slot (fin_slot_a),
        .live     (live),
        .vmask    (vmask),
        .kill     (kill),
        .set_bits (set_bits),
        .bad      (bad)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (bad) begin
            err_q <= 1'b1;
        end
    end

    assign disp_gid  = tail;
    assign iss_mask  = alloc_fire ? disp_mask : '0;
    assign iss_gid   = tail;
    assign iss_tags  = alloc_fire ? disp_tags : '0;
    assign ret_valid = retire_fire;
    assign ret_gid   = head;
    assign ret_mask  = head_mask;
    assign err_flag  = err_q;

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: tb/grp_cmpl_tracker_bench.sv
`timescale 1ns/1ps
module grp_cmpl_tracker_bench;

    localparam int S  = 5;
    localparam int G  = 20;
    localparam int P  = 2;
    localparam int TW = 8;
    localparam int GW = 5;
    localparam int SW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            disp_valid;
    logic [S-1:0]    disp_mask;
    logic [S*TW-1:0] disp_tags;
    logic            disp_ready;
    logic [GW-1:0]   disp_gid;
    logic [S-1:0]    iss_mask;
    logic [GW-1:0]   iss_gid;
    logic [S*TW-1:0] iss_tags;
    logic [P-1:0]    fin_valid;
    logic [P*GW-1:0] fin_gid;
    logic [P*SW-1:0] fin_slot;
    logic            flush_valid;
    logic [GW-1:0]   flush_gid;
    logic            ret_valid;
    logic [GW-1:0]   ret_gid;
    logic [S-1:0]    ret_mask;
    logic            err_flag;

    always #2.5 clk = ~clk;

    grp_cmpl_tracker #(.SLOTS(S), .GROUPS(G), .PORTS(P), .TAG_W(TW)) u_grp_cmpl_tracker (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_mask(disp_mask), .disp_tags(disp_tags),
        .disp_ready(disp_ready), .disp_gid(disp_gid),
        .iss_mask(iss_mask), .iss_gid(iss_gid), .iss_tags(iss_tags),
        .fin_valid(fin_valid), .fin_gid(fin_gid), .fin_slot(fin_slot),
        .flush_valid(flush_valid), .flush_gid(flush_gid),
        .ret_valid(ret_valid), .ret_gid(ret_gid), .ret_mask(ret_mask),
        .err_flag(err_flag)
    );

    // reference model
    int           m_head, m_count;
    bit           m_live [G];
    logic [S-1:0] m_vm   [G];
    logic [S-1:0] m_fm   [G];
    bit           m_err;
    int           n_chk, n_err;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int age(input int g);
        return (g - m_head + G) % G;
    endfunction

    function automatic int m_tail();
        return (m_head + m_count) % G;
    endfunction

    function automatic bit flush_hit();
        return flush_valid && (int'(flush_gid) < G) && (age(int'(flush_gid)) < m_count);
    endfunction

    function automatic bit exp_ret();
        if (m_count == 0) return 1'b0;
        if (m_fm[m_head] != m_vm[m_head]) return 1'b0;
        if (flush_hit() && (int'(flush_gid) == m_head)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit exp_acc();
        return disp_valid && !flush_valid && (m_count < G) && (disp_mask != '0);
    endfunction

    function automatic void model_update();
        bit fh, rt, ac;
        int fa, tl;
        int ages [G];
        fh = flush_hit();
        fa = fh ? age(int'(flush_gid)) : 0;
        rt = exp_ret();
        ac = exp_acc();
        tl = m_tail();
        for (int e = 0; e < G; e++) ages[e] = age(e);
        for (int p = 0; p < P; p++) begin
            int g, s;
            g = int'(fin_gid[p*GW +: GW]);
            s = int'(fin_slot[p*SW +: SW]);
            if (fin_valid[p]) begin
                if (fh && g < G && ages[g] >= fa) begin
                end else if (g >= G || s >= S) begin
                    m_err = 1'b1;
                end else if (!m_live[g] || !m_vm[g][s]) begin
                    m_err = 1'b1;
                end else begin
                    m_fm[g][s] = 1'b1;
                end
            end
        end
        if (rt) begin
            m_live[m_head] = 1'b0;
            m_head = (m_head + 1) % G;
        end
        if (fh) begin
            for (int e = 0; e < G; e++)
                if (ages[e] >= fa) m_live[e] = 1'b0;
            m_count = fa - int'(rt);
        end else begin
            m_count = m_count - int'(rt) + int'(ac);
        end
        if (ac) begin
            m_live[tl] = 1'b1;
            m_vm[tl]   = disp_mask;
            m_fm[tl]   = '0;
        end
    endfunction

    task automatic clear_in();
        disp_valid  = 1'b0;
        disp_mask   = '0;
        disp_tags   = '0;
        fin_valid   = '0;
        fin_gid     = '0;
        fin_slot    = '0;
        flush_valid = 1'b0;
        flush_gid   = '0;
    endtask

    task automatic set_fin(input int p, input int g, input int s);
        fin_valid[p]          = 1'b1;
        fin_gid[p*GW +: GW]   = GW'(g);
        fin_slot[p*SW +: SW]  = SW'(s);
    endtask

    // inputs already driven at the falling edge
    task automatic step();
        bit er, ac;
        #1;
        er = exp_ret();
        ac = exp_acc();
        chk("R4", "disp_ready", int'(disp_ready), int'((m_count < G) && !flush_valid));
        if (disp_ready) chk("R2", "disp_gid", int'(disp_gid), m_tail());
        chk("R2", "iss_mask", int'(iss_mask), ac ? int'(disp_mask) : 0);
        if (ac) begin
            chk("R2", "iss_gid", int'(iss_gid), m_tail());
            chk("R2", "iss_tags_low", int'(iss_tags[31:0]), int'(disp_tags[31:0]));
        end
        chk("R5", "ret_valid", int'(ret_valid), int'(er));
        if (er) begin
            chk("R6", "ret_gid", int'(ret_gid), m_head);
            chk("R5", "ret_mask", int'(ret_mask), int'(m_vm[m_head]));
        end
        chk("R9", "err_flag", int'(err_flag), int'(m_err));
        @(posedge clk);
        model_update();
        @(negedge clk);
        clear_in();
    endtask

    task automatic dispatch(input logic [S-1:0] mk);
        disp_valid = 1'b1;
        disp_mask  = mk;
        disp_tags  = {$urandom, 8'($urandom)};
        step();
    endtask

    task automatic pick_fin(input int p);
        int r, g, s0;
        logic [S-1:0] pend;
        if (m_count == 0) return;
        r = int'($urandom % 32'(m_count));
        g = (m_head + r) % G;
        pend = m_vm[g] & ~m_fm[g];
        if (pend == '0) pend = m_vm[g];
        s0 = int'($urandom % S);
        for (int k = 0; k < S; k++) begin
            int s;
            s = (s0 + k) % S;
            if (pend[s]) begin
                set_fin(p, g, s);
                return;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd9183));
        n_chk = 0;
        n_err = 0;
        m_head = 0;
        m_count = 0;
        m_err = 1'b0;
        for (int e = 0; e < G; e++) begin
            m_live[e] = 1'b0;
            m_vm[e] = '0;
            m_fm[e] = '0;
        end
        clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "reset ready", int'(disp_ready), 1);
        chk("R1", "reset ret_valid", int'(ret_valid), 0);
        chk("R1", "reset err", int'(err_flag), 0);
        @(negedge clk);

        // R3 zero mask allocates nothing
        dispatch(5'b00000);
        #1 chk("R3", "gid after empty mask", int'(disp_gid), 0);
        dispatch(5'b00011);   // gid 0
        dispatch(5'b11111);   // gid 1
        dispatch(5'b00100);   // gid 2

        // R6: younger group 1 finishes first and must wait
        set_fin(0, 1, 0); set_fin(1, 1, 1); step();
        set_fin(0, 1, 2); set_fin(1, 1, 3); step();
        set_fin(0, 1, 4); step();
        #1 chk("R6", "younger complete held", int'(ret_valid), 0);

        // R7: both ports hit group 0 in one cycle
        set_fin(0, 0, 0); set_fin(1, 0, 1); step();
        #1;
        chk("R7", "dual finish retire", int'(ret_valid), 1);
        chk("R7", "dual finish gid", int'(ret_gid), 0);
        step();
        #1;
        chk("R6", "in-order next gid", int'(ret_gid), 1);
        chk("R6", "in-order next valid", int'(ret_valid), 1);
        step();

        // R8 / R10: flush gid 4 with a same-cycle finish into it
        dispatch(5'b00001);   // gid 3
        dispatch(5'b00001);   // gid 4
        dispatch(5'b00001);   // gid 5
        flush_valid = 1'b1;
        flush_gid   = 5'd4;
        set_fin(0, 4, 0);
        set_fin(1, 2, 2);
        step();
        #1;
        chk("R10", "dropped finish no error", int'(err_flag), 0);
        chk("R8", "dispatch reuses flushed gid", int'(disp_gid), 4);
        chk("R8", "older group retires", int'(ret_valid), 1);
        chk("R8", "older group gid", int'(ret_gid), 2);
        step();

        // R4: fill the ring
        while (m_count < G) dispatch(5'b00001);
        #1 chk("R4", "full ready", int'(disp_ready), 0);
        dispatch(5'b00111);
        #1 chk("R4", "full still", int'(disp_ready), 0);

        // R9: slot outside the head group's mask
        set_fin(0, m_head, 4);
        step();
        #1 chk("R9", "bad slot sets err", int'(err_flag), 1);
        set_fin(0, 25, 0);
        step();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 100 < 55) begin
                disp_valid = 1'b1;
                disp_mask  = ($urandom % 8 == 0) ? '0 : S'($urandom);
                disp_tags  = {$urandom, 8'($urandom)};
            end
            for (int p = 0; p < P; p++) begin
                if ($urandom % 100 < 75) pick_fin(p);
                else if ($urandom % 100 < 4) set_fin(p, int'($urandom % 32), int'($urandom % 8));
            end
            if ($urandom % 100 < 3) begin
                flush_valid = 1'b1;
                flush_gid   = ($urandom % 10 == 0) ? GW'($urandom) : GW'($urandom % G);
            end
            step();
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule